// File: doc/BRIEF.md
# Prioritized CAN Receive Interrupt Generator

This block produces the receive interrupt for a CAN receive path. A filter stage upstream tells it which acceptance filter an incoming message matched, and the receive FIFO reports its fill level. Each filter owns one priority bit. A message that matches a filter whose bit is set raises the interrupt at once, which suits alarm traffic. A match on a filter whose bit is clear raises nothing by itself. The interrupt then waits until the FIFO holds more entries than a programmable threshold.

The host programs two registers through a simple single-cycle read/write port. One holds the per-filter priority bits, which are arranged as banks of two filters. The other holds the threshold. The number of filter banks actually built is a parameter. Priority bits of banks that are not built read back as zero and keep no written value. The interrupt output is sticky. The host removes it with a clear strobe. The threshold part also falls away by itself once the FIFO level is no longer above the threshold.

Top module: `can_rx_irq_gen`

## Requirements
- R1: After reset `rx_irq` is 0, and both the priority register and the threshold register read 0.
- R2: Writing address 31 stores the priority register and reading address 31 returns it. Bit 2*(b-1)+(f-1) belongs to bank b, filter f: bit 0 is bank 1 filter 1, bit 1 is bank 1 filter 2, and so on up to bit 7, which is bank 4 filter 2.
- R3: Priority bits of banks numbered above `NUM_BANKS` (bits 7:6 with the default of 3) always read 0 and ignore writes. A hit on such a filter never raises an immediate interrupt.
- R4: Address 30 is the read/write threshold register. Any other address reads 0.
- R5: A store strobe whose one-hot `filt_hit` selects a filter with priority bit 1 sets `rx_irq` on the next clock edge, whatever the FIFO level is.
- R6: A store that hits a priority-0 filter, a store with all-zero `filt_hit`, or a `filt_hit` pattern without a store strobe raises no immediate interrupt.
- R7: `rx_irq` rises on the edge after `fifo_level` becomes strictly greater than the threshold register. A level equal to the threshold does not raise it.
- R8: `irq_clr` clears `rx_irq` on the next edge. While the level stays above the threshold, the interrupt comes back only after the level has dropped to or below the threshold and then risen above it again.
- R9: The threshold interrupt goes away by itself one edge after the level falls to or below the threshold. A pending immediate interrupt stays until `irq_clr`.
- R10: An immediate event and a threshold crossing in the same cycle give one assertion of `rx_irq`, and a single `irq_clr` removes it.
- R11: When an immediate event and `irq_clr` arrive in the same cycle, the event wins and `rx_irq` is 1 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on `reg_addr`) |
| store_stb | input | 1 | High for one cycle when an accepted message is stored |
| filt_hit | input | 8 | One-hot index of the matched filter, sampled with `store_stb` |
| fifo_level | input | 8 | Current receive FIFO fill level |
| irq_clr | input | 1 | Host clear strobe for the interrupt |
| rx_irq | output | 1 | Sticky receive interrupt |

## Verification
The immediate path is driven with hits on priority-1 filters, priority-0 filters, an unbuilt bank's filter, an all-zero hit and a hit without a strobe. These cases separate masking by the priority bit from gating by the strobe and from gating by the bank count. The threshold path is swept through equal, above, cleared-while-above, dropped and re-raised levels. That shows the strict comparison and the crossing rearm. It also shows self-clearing as distinct from host clearing. Finally the two paths are combined: an immediate event while a threshold interrupt is active, a simultaneous event and crossing, and an event coinciding with a clear. These cases show that the two sources merge into one flag with the stated precedence.

// File: rtl/can_rxirq_pkg.sv
package can_rxirq_pkg;

  // Mask with one bit set for every filter that belongs to a built bank.
  function automatic logic [63:0] built_mask(input int nbanks, input int per_bank);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < nbanks * per_bank) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Strict "greater than" between a FIFO level and the programmed threshold.
  function automatic logic above_threshold(input logic [15:0] level, input logic [15:0] thr);
    return level > thr;
  endfunction

endpackage

// File: rtl/rxirq_regs.sv
module rxirq_regs #(
  parameter int MAX_BANKS  = 4,
  parameter int PER_BANK   = 2,
  parameter int NUM_BANKS  = 3,
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LVL_W      = 8,
  parameter int PRIO_ADDR  = 31,
  parameter int THR_ADDR   = 30,
  localparam int TOTAL_F   = MAX_BANKS * PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [TOTAL_F-1:0] prio_bits,
  output logic [LVL_W-1:0]  thr_level
);
  import can_rxirq_pkg::*;

  localparam logic [63:0] MASK_W = built_mask(NUM_BANKS, PER_BANK);
  localparam logic [TOTAL_F-1:0] BUILT = MASK_W[TOTAL_F-1:0];

  logic [TOTAL_F-1:0] prio_q;
  logic [LVL_W-1:0]   thr_q;
  logic               hit_prio_addr;
  logic               hit_thr_addr;
  logic               wr_prio;
  logic               wr_thr;

  assign hit_prio_addr = (reg_addr == ADDR_W'(PRIO_ADDR));
  assign hit_thr_addr  = (reg_addr == ADDR_W'(THR_ADDR));
  assign wr_prio       = reg_wr && hit_prio_addr;
  assign wr_thr        = reg_wr && hit_thr_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      thr_q  <= '0;
    end else begin
      if (wr_prio) prio_q <= reg_wdata[TOTAL_F-1:0] & BUILT;
      if (wr_thr)  thr_q  <= reg_wdata[LVL_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_prio_addr)     reg_rdata = DATA_W'(prio_q);
    else if (hit_thr_addr) reg_rdata = DATA_W'(thr_q);
  end

  assign prio_bits = prio_q;
  assign thr_level = thr_q;

  // R2: a priority write is visible on the following cycle, masked to built banks
  a_r2_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prio |=> prio_q == ($past(reg_wdata[TOTAL_F-1:0]) & BUILT));

  // R3: unbuilt-bank bits never hold a one
  a_r3_unbuilt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q & ~BUILT) == '0);

  // R4: the threshold register keeps its value when not written
  a_r4_thr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_thr |=> $stable(thr_q));

endmodule

// File: rtl/rxirq_imm_detect.sv
module rxirq_imm_detect #(
  parameter int MAX_BANKS = 4,
  parameter int PER_BANK  = 2,
  parameter int NUM_BANKS = 3,
  localparam int TOTAL_F  = MAX_BANKS * PER_BANK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               store_stb,
  input  logic [TOTAL_F-1:0] filt_hit,
  input  logic [TOTAL_F-1:0] prio_bits,
  input  logic               irq_clr,
  output logic               imm_event,
  output logic               imm_pend
);
  logic [TOTAL_F-1:0] urgent_match;

  // One slot per filter; banks that are not built contribute nothing.
  for (genvar b = 0; b < MAX_BANKS; b++) begin : g_bank
    for (genvar f = 0; f < PER_BANK; f++) begin : g_filt
      localparam int IDX = b * PER_BANK + f;
      if (b < NUM_BANKS) begin : g_built
        assign urgent_match[IDX] = filt_hit[IDX] & prio_bits[IDX];
      end else begin : g_absent
        assign urgent_match[IDX] = 1'b0;
      end
    end
  end

  assign imm_event = store_stb && (|urgent_match);

  always_ff @(posedge clk) begin
    if (!rst_n)         imm_pend <= 1'b0;
    else if (imm_event) imm_pend <= 1'b1;
    else if (irq_clr)   imm_pend <= 1'b0;
  end

  // R5: an urgent store always leaves the pending flag set (also covers R11)
  a_r5_imm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    imm_event |=> imm_pend);

  // R6: the immediate flag only rises after a store strobe
  a_r6_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(imm_pend) |-> $past(store_stb));

  // R6: filter hits are one-hot whenever they are sampled
  a_r6_onehot_hit: assert property (@(posedge clk) disable iff (!rst_n)
    store_stb |-> $onehot0(filt_hit));

  // R9: without a clear the immediate flag does not fall
  a_r9_imm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_pend && !irq_clr) |=> imm_pend);

endmodule

// File: rtl/rxirq_thr_track.sv
module rxirq_thr_track #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] thr_level,
  input  logic             irq_clr,
  output logic             thr_over,
  output logic             thr_cross,
  output logic             thr_pend
);
  import can_rxirq_pkg::*;

  logic over_q;

  assign thr_over  = above_threshold(16'(fifo_level), 16'(thr_level));
  assign thr_cross = thr_over && !over_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      over_q   <= 1'b0;
      thr_pend <= 1'b0;
    end else begin
      over_q <= thr_over;
      if (thr_cross)                 thr_pend <= 1'b1;
      else if (irq_clr || !thr_over) thr_pend <= 1'b0;
    end
  end

  // R7: a crossing sets the threshold flag
  a_r7_cross_sets: assert property (@(posedge clk) disable iff (!rst_n)
    thr_cross |=> thr_pend);

  // R9: the threshold flag is gone once the level is not above the threshold
  a_r9_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_over |=> !thr_pend);

  // R8: after a clear the flag cannot return without a fresh crossing
  a_r8_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !thr_cross) |=> !thr_pend);

endmodule

// File: rtl/can_rx_irq_gen.sv
module can_rx_irq_gen #(
  parameter int MAX_BANKS = 4,
  parameter int PER_BANK  = 2,
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 8,
  parameter int LVL_W     = 8,
  parameter int PRIO_ADDR = 31,
  parameter int THR_ADDR  = 30,
  localparam int TOTAL_F  = MAX_BANKS * PER_BANK
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               store_stb,
  input  logic [TOTAL_F-1:0] filt_hit,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               irq_clr,
  output logic               rx_irq
);
  logic [TOTAL_F-1:0] prio_bits;
  logic [LVL_W-1:0]   thr_level;
  logic               imm_event;
  logic               imm_pend;
  logic               thr_over;
  logic               thr_cross;
  logic               thr_pend;

  rxirq_regs #(
    .MAX_BANKS(MAX_BANKS), .PER_BANK(PER_BANK), .NUM_BANKS(NUM_BANKS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W),
    .PRIO_ADDR(PRIO_ADDR), .THR_ADDR(THR_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .prio_bits(prio_bits), .thr_level(thr_level)
  );

  rxirq_imm_detect #(
    .MAX_BANKS(MAX_BANKS), .PER_BANK(PER_BANK), .NUM_BANKS(NUM_BANKS)
  ) u_imm (
    .clk(clk), .rst_n(rst_n), .store_stb(store_stb), .filt_hit(filt_hit),
    .prio_bits(prio_bits), .irq_clr(irq_clr),
    .imm_event(imm_event), .imm_pend(imm_pend)
  );

  rxirq_thr_track #(.LVL_W(LVL_W)) u_thr (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .thr_level(thr_level),
    .irq_clr(irq_clr), .thr_over(thr_over), .thr_cross(thr_cross),
    .thr_pend(thr_pend)
  );

  // Both sources merge into one flag; simultaneous events give one level.
  assign rx_irq = imm_pend | thr_pend;

  // R10/R11: any source event in a cycle leaves the interrupt set
  a_r10_any_event: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_event || thr_cross) |=> rx_irq);

  // R8: a clear with no new event drops the interrupt
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !imm_event && !thr_cross) |=> !rx_irq);

  // R1: the interrupt never rises without a cause in the prior cycle
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(imm_event || thr_cross));

endmodule

// File: tb/can_rx_irq_gen_test.sv
module can_rx_irq_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       store_stb;
  logic [7:0] filt_hit;
  logic [7:0] fifo_level;
  logic       irq_clr;
  logic       rx_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct { bit exp; string req; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  can_rx_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .store_stb(store_stb),
    .filt_hit(filt_hit), .fifo_level(fifo_level), .irq_clr(irq_clr),
    .rx_irq(rx_irq)
  );

  // Monitor: after each edge, compare rx_irq against the queued expectation.
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      n_tests++;
      if (rx_irq !== it.exp) begin
        n_fail++;
        $display("FAIL %s: rx_irq=%0b expected %0b", it.req, rx_irq, it.exp);
      end
    end
  end

  // Driver: apply one cycle of stimulus and queue the expected interrupt.
  task automatic cyc(input bit stb, input logic [7:0] hit, input logic [7:0] lvl,
                     input bit clr, input bit exp, input string req);
    @(negedge clk);
    reg_wr = 1'b0; store_stb = stb; filt_hit = hit; fifo_level = lvl; irq_clr = clr;
    sb_q.push_back('{exp, req});
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [7:0] d, input bit exp, input string req);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    store_stb = 1'b0; filt_hit = '0; irq_clr = 1'b0;
    sb_q.push_back('{exp, req});
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = a; store_stb = 1'b0; irq_clr = 1'b0;
    #1;
    n_tests++;
    if (reg_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata[%0d]=%02h expected %02h", req, a, reg_rdata, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    store_stb = 1'b0; filt_hit = '0; fifo_level = '0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_chk(5'd31, 8'h00, "R1 prio reset");
    rd_chk(5'd30, 8'h00, "R1 thr reset");
    cyc(0, 8'h00, 8'd0, 0, 0, "R1 irq reset");

    // R2/R3: priority register; bank 4 (bits 7:6) not built
    wr_reg(5'd31, 8'hFF, 0, "R3 write all");
    rd_chk(5'd31, 8'h3F, "R3 unbuilt bits read 0");
    wr_reg(5'd31, 8'hC5, 0, "R2 write bank1f1 bank2f1");
    rd_chk(5'd31, 8'h05, "R2 readback");
    // R4: threshold register and unused address
    wr_reg(5'd30, 8'd4, 0, "R4 write thr");
    rd_chk(5'd30, 8'd4, "R4 thr readback");
    rd_chk(5'd5, 8'h00, "R4 unused addr");

    // R5: bank 1 filter 1 (bit 0) urgent
    cyc(1, 8'h01, 8'd0, 0, 1, "R5 urgent bit0");
    cyc(0, 8'h00, 8'd0, 0, 1, "R5 held");
    cyc(0, 8'h00, 8'd0, 1, 0, "R8 clear imm");
    // R6: bank 1 filter 2 (bit 1) low priority
    cyc(1, 8'h02, 8'd0, 0, 0, "R6 low prio bit1");
    // R5: bank 2 filter 1 (bit 2) urgent
    cyc(1, 8'h04, 8'd0, 0, 1, "R5 urgent bit2");
    cyc(0, 8'h00, 8'd0, 1, 0, "R8 clear");
    cyc(0, 8'h01, 8'd0, 0, 0, "R6 hit without strobe");
    cyc(1, 8'h00, 8'd0, 0, 0, "R6 strobe no hit");
    cyc(1, 8'h40, 8'd0, 0, 0, "R3 unbuilt bank hit");

    // R7: threshold 4
    cyc(0, 8'h00, 8'd4, 0, 0, "R7 equal level");
    cyc(0, 8'h00, 8'd5, 0, 1, "R7 above level");
    cyc(0, 8'h00, 8'd5, 1, 0, "R8 clear while above");
    cyc(0, 8'h00, 8'd6, 0, 0, "R8 no rearm above");
    cyc(0, 8'h00, 8'd3, 0, 0, "R8 drop");
    cyc(0, 8'h00, 8'd6, 0, 1, "R8 recross");
    cyc(0, 8'h00, 8'd2, 0, 0, "R9 self clear");

    // R9: immediate survives level drop
    cyc(0, 8'h00, 8'd6, 0, 1, "R9 thr set");
    cyc(1, 8'h01, 8'd6, 0, 1, "R9 imm on top");
    cyc(0, 8'h00, 8'd1, 0, 1, "R9 imm survives drop");
    cyc(0, 8'h00, 8'd1, 1, 0, "R9 clear imm");

    // R10: simultaneous urgent store and crossing
    cyc(1, 8'h04, 8'd7, 0, 1, "R10 both");
    cyc(0, 8'h00, 8'd7, 1, 0, "R10 single clear");
    cyc(0, 8'h00, 8'd0, 0, 0, "R10 stays clear");

    // R11: event and clear together
    cyc(1, 8'h01, 8'd0, 1, 1, "R11 set wins");
    cyc(0, 8'h00, 8'd0, 1, 0, "R11 cleared");
    cyc(0, 8'h00, 8'd0, 0, 0, "R11 idle");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule